// File: doc/BRIEF.md
# Nonrestoring Division Step Unit

This block performs one step of an unsigned nonrestoring division each time a step is accepted. It keeps three pieces of state between steps: a single carry bit, a direction word whose top bit selects add or subtract, and a vector holding the carry into every bit of the last addition. A step shifts the supplied partial remainder left by one, puts the stored carry bit into the vacated low bit, and then adds or subtracts the divisor. The direction comes from the stored direction word, not from a comparison. The sum becomes the new partial remainder, and the state registers take the carry-out, the per-bit carries and a new direction word.

Surrounding control runs a full division as a loop of steps. Before each step it places the next dividend bit into the carry bit through the load port. After the step it reads the carry bit back as the next quotient bit. When the loop ends, a negative final remainder is corrected by adding the divisor once. Step operands arrive on a valid/ready channel and each new remainder leaves on a valid/ready channel.

The result channel holds one entry. A step is accepted only when that entry is empty or is being taken in the same cycle. While a result waits with `res_ready` low, `step_ready` stays low, so the remainder and all state hold still. The load port is a plain control input: it has priority, and `step_ready` is low in any cycle in which `load_en` is high.

Top module: `div_step_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `carry_q`, `dir_q`, `cbits_q`, `res_valid` and `rem_out` to zero by the following clock edge.
- R2: With `load_en` high, the next edge writes `load_carry` into `carry_q` and `load_dir` into `dir_q`, and leaves `cbits_q` and `rem_out` unchanged.
- R3: `step_ready` equals `!load_en && (!res_valid || res_ready)`. A step is accepted on an edge where `step_valid && step_ready`, and `res_valid` is high from the next cycle on.
- R4: The first addend of a step is `{rem_in[W-2:0], carry_q}`: the top bit of the remainder is dropped and the stored carry fills bit 0.
- R5: When `dir_q[W-1]` is 1 the second addend is `~divisor` with a carry-in of 1 (subtraction). When it is 0 the second addend is `divisor` with a carry-in of 0. `rem_out` takes the W-bit sum.
- R6: After an accepted step, `carry_q` holds the carry-out of the W-bit addition.
- R7: After an accepted step, `cbits_q` holds first addend XOR second addend XOR sum, which is the carry into each bit position.
- R8: After an accepted step, `dir_q` holds the carry-out replicated to W bits, XOR `divisor`.
- R9: While `res_valid` is high and `res_ready` is low, no step is accepted, and `rem_out` stays stable. `carry_q` and `dir_q` also stay stable unless a load occurs.
- R10: A result is dropped (`res_valid` falls) on an edge with `res_ready` high and no new step accepted.
- R11: For a divisor in 1 to 2^(W-1)-1, the following sequence gives the unsigned quotient and remainder. Start with remainder 0 and direction all ones. Run W load-then-step rounds, loading the dividend bits from the top down. Take each post-step `carry_q` as the next quotient bit from the top down. Add the divisor once if the final step left `carry_q` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Step operands are present |
| step_ready | output | 1 | Unit can accept a step this cycle |
| rem_in | input | W | Partial remainder entering the step |
| divisor | input | W | Divisor |
| res_valid | output | 1 | `rem_out` holds an untaken result |
| res_ready | input | 1 | Consumer takes the result |
| rem_out | output | W | New partial remainder |
| load_en | input | 1 | Preset carry and direction this cycle |
| load_carry | input | 1 | Value preset into the carry bit |
| load_dir | input | W | Value preset into the direction word |
| carry_q | output | 1 | Stored carry bit |
| dir_q | output | W | Stored direction word |
| cbits_q | output | W | Stored per-bit carry vector |

## Verification
The hardest case to reach is the one where two steps in a row add the divisor. That happens only when a subtract step leaves a negative partial remainder and the following add step still does not carry out. The bench reaches it by running full divisions whose divisor is near 2^(W-1) and whose dividend has long runs of zeros. A second case that is hard to reach from the ports is a pending step held off by back-pressure, with new operands waiting while a result sits untaken. The bench reaches it by lowering `res_ready` across several cycles and checking that nothing moves until the result is taken.

// File: rtl/ds_pkg.sv
package ds_pkg;
  // Default datapath width of the division step
  parameter int unsigned DS_DEFAULT_W = 32;

  // Selection of the arithmetic applied in one step
  typedef enum logic {
    DS_ADD = 1'b0,
    DS_SUB = 1'b1
  } ds_op_e;
endpackage

// File: rtl/ds_operand_mux.sv
module ds_operand_mux #(
  parameter int unsigned W = ds_pkg::DS_DEFAULT_W
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] divisor,
  input  logic         carry_q,
  input  logic         dir_msb,
  output logic [W-1:0] add_a,
  output logic [W-1:0] add_b,
  output logic         add_cin
);
  import ds_pkg::*;

  ds_op_e op;

  always_comb begin
    op      = dir_msb ? DS_SUB : DS_ADD;
    // shift left, stored carry into bit 0
    add_a   = {rem_in[W-2:0], carry_q};
    add_b   = (op == DS_SUB) ? ~divisor : divisor;
    add_cin = (op == DS_SUB);
  end

  // R5
  always_comb begin
    invert_sel_chk: assert ((add_b ^ divisor) == {W{add_cin}});
  end
endmodule

// File: rtl/ds_carry_chain.sv
module ds_carry_chain #(
  parameter int unsigned W = ds_pkg::DS_DEFAULT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W-1:0] cvec,
  output logic         cout
);
  logic [W:0] c;

  assign c[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign sum[i]  = a[i] ^ b[i] ^ c[i];
      assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end
  endgenerate

  assign cvec = c[W-1:0];
  assign cout = c[W];

  // R6
  always_comb begin
    ripple_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
  end
endmodule

// File: rtl/ds_state_regs.sv
module ds_state_regs #(
  parameter int unsigned W = ds_pkg::DS_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic         load_carry,
  input  logic [W-1:0] load_dir,
  input  logic         step_fire,
  input  logic         next_carry,
  input  logic [W-1:0] next_dir,
  input  logic [W-1:0] next_cvec,
  output logic         carry_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] cvec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      dir_q   <= '0;
      cvec_q  <= '0;
    end else if (load_en) begin
      carry_q <= load_carry;
      dir_q   <= load_dir;
    end else if (step_fire) begin
      carry_q <= next_carry;
      dir_q   <= next_dir;
      cvec_q  <= next_cvec;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!carry_q && dir_q == '0 && cvec_q == '0));

  // R2
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (carry_q == $past(load_carry) && dir_q == $past(load_dir) && $stable(cvec_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_fire) |=> ($stable(carry_q) && $stable(dir_q) && $stable(cvec_q)));
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit #(
  parameter int unsigned W = ds_pkg::DS_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_valid,
  output logic         step_ready,
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] divisor,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] rem_out,
  input  logic         load_en,
  input  logic         load_carry,
  input  logic [W-1:0] load_dir,
  output logic         carry_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] cbits_q
);
  localparam int unsigned MSB = W - 1;

  logic         fire;
  logic [W-1:0] add_a, add_b, sum, cvec;
  logic         add_cin, cout;
  logic [W-1:0] next_dir;

  assign step_ready = !load_en && (!res_valid || res_ready);
  assign fire       = step_valid && step_ready;
  assign next_dir   = {W{cout}} ^ divisor;

  ds_operand_mux #(.W(W)) u_mux (
    .rem_in  (rem_in),
    .divisor (divisor),
    .carry_q (carry_q),
    .dir_msb (dir_q[MSB]),
    .add_a   (add_a),
    .add_b   (add_b),
    .add_cin (add_cin)
  );

  ds_carry_chain #(.W(W)) u_chain (
    .a    (add_a),
    .b    (add_b),
    .cin  (add_cin),
    .sum  (sum),
    .cvec (cvec),
    .cout (cout)
  );

  ds_state_regs #(.W(W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .load_carry (load_carry),
    .load_dir   (load_dir),
    .step_fire  (fire),
    .next_carry (cout),
    .next_dir   (next_dir),
    .next_cvec  (cvec),
    .carry_q    (carry_q),
    .dir_q      (dir_q),
    .cvec_q     (cbits_q)
  );

  // one-entry result slot
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      rem_out   <= '0;
    end else if (fire) begin
      res_valid <= 1'b1;
      rem_out   <= sum;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R3
  load_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !step_ready);

  // R3
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_ready) |=> res_valid);

  // R8
  dir_update_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_ready) |=> (dir_q == ({W{carry_q}} ^ $past(divisor))));

  // R9
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready && !load_en) |=>
      (res_valid && $stable(rem_out) && $stable(carry_q) && $stable(dir_q)));

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (res_ready && !(step_valid && step_ready)) |=> !res_valid);
endmodule

// File: tb/tb_div_step_unit.sv
module tb_div_step_unit;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG_CYCLES = 150000;

  logic         clk = 1'b0;
  logic         rst;
  logic         step_valid;
  logic         step_ready;
  logic [W-1:0] rem_in, divisor;
  logic         res_valid;
  logic         res_ready;
  logic [W-1:0] rem_out;
  logic         load_en, load_carry;
  logic [W-1:0] load_dir;
  logic         carry_q;
  logic [W-1:0] dir_q, cbits_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  div_step_unit #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .step_valid(step_valid), .step_ready(step_ready),
    .rem_in(rem_in), .divisor(divisor),
    .res_valid(res_valid), .res_ready(res_ready), .rem_out(rem_out),
    .load_en(load_en), .load_carry(load_carry), .load_dir(load_dir),
    .carry_q(carry_q), .dir_q(dir_q), .cbits_q(cbits_q)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // step arithmetic as stated by R4..R8
  task automatic model(input logic [W-1:0] r, input logic [W-1:0] d, input logic c,
                       input logic [W-1:0] dir, output logic [W-1:0] s, output logic co,
                       output logic [W-1:0] cb, output logic [W-1:0] nd);
    logic [W-1:0] a, b;
    logic [W:0] full;
    a = {r[W-2:0], c};
    b = dir[W-1] ? ~d : d;
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, dir[W-1]};
    s = full[W-1:0];
    co = full[W];
    cb = a ^ b ^ s;
    nd = {W{co}} ^ d;
  endtask

  task automatic do_load(input logic c, input logic [W-1:0] dir);
    @(negedge clk);
    load_en = 1'b1; load_carry = c; load_dir = dir;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_step(input logic [W-1:0] r, input logic [W-1:0] d);
    @(negedge clk);
    step_valid = 1'b1; rem_in = r; divisor = d; res_ready = 1'b1;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step_valid = 1'b0; res_ready = 1'b1; load_en = 1'b0;
    load_carry = 1'b0; load_dir = '0; rem_in = '0; divisor = '0;
    repeat (3) @(negedge clk);
    // R1
    check(!carry_q && dir_q == '0 && cbits_q == '0 && !res_valid && rem_out == '0,
          "R1 reset state", {cbits_q[W-1:2], res_valid, carry_q}, '0);
    rst = 1'b0;
  endtask

  task automatic t_load();
    logic [W-1:0] cb_before;
    cb_before = cbits_q;
    @(negedge clk);
    load_en = 1'b1; load_carry = 1'b1; load_dir = 32'hA5A5_0F0F; step_valid = 1'b1;
    #1;
    // R3: load holds off steps
    check(step_ready == 1'b0, "R3 ready low during load", {31'b0, step_ready}, '0);
    @(negedge clk);
    load_en = 1'b0; step_valid = 1'b0;
    // R2
    check(carry_q == 1'b1, "R2 load carry", {31'b0, carry_q}, 1);
    check(dir_q == 32'hA5A5_0F0F, "R2 load dir", dir_q, 32'hA5A5_0F0F);
    check(cbits_q == cb_before && !res_valid, "R2 load leaves cbits and result", cbits_q, cb_before);
  endtask

  task automatic t_step_add();
    logic [W-1:0] s, cb, nd; logic co;
    do_load(1'b1, 32'h0000_0000);
    model(32'h8000_0001, 32'h7FFF_FFFF, 1'b1, 32'h0, s, co, cb, nd);
    do_step(32'h8000_0001, 32'h7FFF_FFFF);
    // R4: msb dropped, carry in bit 0 -> 3 + 0x7FFFFFFF
    check(rem_out == 32'h8000_0002 && res_valid, "R4 shifted addend", rem_out, 32'h8000_0002);
    check(rem_out == s, "R5 add path sum", rem_out, s);
    check(carry_q == co, "R6 add carry out", {31'b0, carry_q}, {31'b0, co});
    check(cbits_q == cb, "R7 add carry vector", cbits_q, cb);
    check(dir_q == nd, "R8 add direction", dir_q, nd);
  endtask

  task automatic t_step_sub();
    logic [W-1:0] s, cb, nd; logic co;
    do_load(1'b0, 32'hFFFF_FFFF);
    model(32'd5, 32'd3, 1'b0, 32'hFFFF_FFFF, s, co, cb, nd);
    do_step(32'd5, 32'd3);
    // R5: 10 - 3
    check(rem_out == 32'd7, "R5 subtract sum", rem_out, 32'd7);
    check(carry_q == 1'b1, "R6 subtract no borrow", {31'b0, carry_q}, 1);
    check(cbits_q == cb, "R7 subtract carry vector", cbits_q, cb);
    check(dir_q == 32'hFFFF_FFFC, "R8 subtract direction", dir_q, 32'hFFFF_FFFC);
    // borrow case: 0 - 9 with carry 0
    do_load(1'b0, 32'h8000_0000);
    model(32'd0, 32'd9, 1'b0, 32'h8000_0000, s, co, cb, nd);
    do_step(32'd0, 32'd9);
    check(rem_out == s && rem_out == 32'hFFFF_FFF7, "R5 subtract borrow sum", rem_out, 32'hFFFF_FFF7);
    check(carry_q == 1'b0, "R6 borrow clears carry", {31'b0, carry_q}, 0);
    check(dir_q == 32'd9, "R8 borrow direction", dir_q, 32'd9);
  endtask

  task automatic t_backpressure();
    logic [W-1:0] held, dheld, s, cb, nd; logic cheld, co;
    do_load(1'b0, 32'h0);
    @(negedge clk);
    step_valid = 1'b1; rem_in = 32'd100; divisor = 32'd20; res_ready = 1'b0;
    @(negedge clk);
    held = rem_out; cheld = carry_q; dheld = dir_q;
    check(res_valid && held == 32'd220, "R3 result after accept", held, 32'd220);
    rem_in = 32'd7; divisor = 32'd1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!step_ready, "R9 ready low under back-pressure", {31'b0, step_ready}, 0);
      @(negedge clk);
      check(rem_out == held && carry_q == cheld && dir_q == dheld && res_valid,
            "R9 state held", rem_out, held);
    end
    model(32'd7, 32'd1, cheld, dheld, s, co, cb, nd);
    res_ready = 1'b1;
    @(negedge clk);
    step_valid = 1'b0;
    check(rem_out == s && res_valid, "R3 pending step taken with ready", rem_out, s);
    @(negedge clk);
    // R10
    check(!res_valid, "R10 result dropped", {31'b0, res_valid}, 0);
  endtask

  task automatic t_divide(input logic [W-1:0] n, input logic [W-1:0] d);
    logic [W-1:0] r, q, dir;
    r = '0; q = '0; dir = '1;
    for (int i = W - 1; i >= 0; i--) begin
      do_load(n[i], dir);
      do_step(r, d);
      r = rem_out;
      dir = dir_q;
      q = {q[W-2:0], carry_q};
    end
    if (!carry_q) r = r + d;
    // R11
    check(q == n / d, "R11 quotient", q, n / d);
    check(r == n % d, "R11 remainder", r, n % d);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_step_add();
    t_step_sub();
    t_backpressure();
    t_divide(32'd100, 32'd7);
    t_divide(32'hFFFF_FFFF, 32'd1);
    t_divide(32'd5, 32'd9);
    t_divide(32'h8000_0000, 32'h7FFF_FFFF);
    t_divide(32'h0001_0000, 32'h7FFF_FFFE);
    t_divide(32'hDEAD_BEEF, 32'h0000_1234);
    for (int k = 0; k < 10; k++) begin
      logic [W-1:0] n, d;
      n = $urandom();
      d = ($urandom() & 32'h7FFF_FFFF) | 32'd1;
      if (k % 2 == 0) d = d >> (k * 3);
      if (d == 0) d = 32'd3;
      t_divide(n, d);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule